// File: doc/BRIEF.md
# Boundary-Scan Bidirectional Pin Cell

This block wraps one bidirectional digital port pin with a boundary-scan cell and the normal port logic that the cell can override. Output control, output data and input data share a scan path that is only two flip-flops long: the stage nearest the scan input holds the control bit, and the stage nearest the scan output holds the data bit. The capture, shift and update strobes come from an external test access port, and a two-bit instruction decode tells the cell whether the external-test instruction, the sample/preload instruction or anything else is loaded.

Outside the scan instructions the pad follows the port and direction register bits, and the pull-up follows the usual rule. While either scan instruction is loaded, the pull-up is forced off and the system clock is kept off the clock-output pin. Under external test the update latches drive the pad. Scan capture reads the raw pad level. The normal pin read goes through a two-flop synchronizer in the system clock domain.

Top module: `bscan_pin_cell`

## Requirements
- R1: `insn` encodes 2'b01 as external test, 2'b10 as sample/preload, and 2'b00 and 2'b11 as normal. In every encoding except 2'b01, `pad_oe` equals `dir_bit` and `pad_out` equals `port_bit`.
- R2: In normal encodings, `pullup_en` is 1 exactly when `pud` is 0, `dir_bit` is 0 and `port_bit` is 1.
- R3: While `insn` is 2'b01 or 2'b10, `pullup_en` is 0 whatever the register bits are.
- R4: On a rising `tck` edge with `capture_en` high, the data stage loads `pad_in` and the control stage loads `dir_bit`. `scan_out` shows the data stage directly.
- R5: On a rising `tck` edge with `shift_en` high and `capture_en` low, the control stage loads `scan_in` and the data stage loads the control stage. A bit shifted in reaches `scan_out` after two such edges.
- R6: On a falling `tck` edge with `update_en` high, the update latches copy both stages. Under external test, `pad_oe` shows the control latch and `pad_out` shows the data latch. Shifting without an update leaves the pad unchanged.
- R7: Under sample/preload, capture, shift and update leave the pad under normal port control. Values preloaded by an update appear on the pad as soon as external test is selected.
- R8: `pin_read` is `pad_in` passed through two `sys_clk` flops. A change is visible after the second rising edge and not after the first.
- R9: While `sys_clk` is high, `clk_out_pad` is 1 only when `clk_out_en` is 1 and neither scan instruction is loaded. While `sys_clk` is low it is 0.
- R10: `trst_n` low at once clears both scan stages and both update latches. `sys_rst_n` low at once clears the read synchronizer. Each reset is released after two rising edges of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the pin read path and the clock output |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the system clock domain |
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset of the scan logic |
| insn | input | 2 | Instruction decode: 01 external test, 10 sample/preload |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial scan input |
| scan_out | output | 1 | Serial scan output (data stage) |
| port_bit | input | 1 | Port register bit |
| dir_bit | input | 1 | Direction register bit, 1 = output |
| pud | input | 1 | Global pull-up disable |
| clk_out_en | input | 1 | Clock output enabled by configuration |
| pad_in | input | 1 | Level seen on the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output data |
| pullup_en | output | 1 | Pad pull-up enable |
| pin_read | output | 1 | Synchronized pin value |
| clk_out_pad | output | 1 | Gated system clock to the clock-output pin |

## Verification
The pad enable, pad data, pull-up and clock-output results are combinational, so the bench reads them one time unit after it changes an input. Capture and shift results are due on the rising test-clock edge, and update results on the falling edge of the same test-clock period, so each test-clock period is driven as one unit and `scan_out` and the pad are read a few units after the falling edge. `pin_read` is due on the second rising `sys_clk` edge after `pad_in` changes. The bench changes `pad_in` just after an edge and reads once after the next edge, where the old value is expected, and once after the edge after that, where the new value is expected.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    INSN_NORMAL  = 2'b00,
    INSN_EXTEST  = 2'b01,
    INSN_SAMPLE  = 2'b10,
    INSN_NORMAL3 = 2'b11
  } insn_e;

  typedef struct packed {
    logic ctl;
    logic dat;
  } cell_pair_t;
endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] q_nxt;

  always_comb begin
    q_nxt = {q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_nxt;
  end

  assign rst_n = q[STAGES-1];
endmodule

// File: rtl/bscan_pin_sync.sv
module bscan_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stg_nxt;
    if (i == 0) begin : g_first
      assign stg_nxt = d;
    end else begin : g_rest
      assign stg_nxt = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= 1'b0;
      else        stg[i] <= stg_nxt;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bscan_scan_reg.sv
module bscan_scan_reg
  import bscan_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic update_en,
  input  logic scan_in,
  input  logic cap_ctl,
  input  logic cap_dat,
  output logic scan_out,
  output cell_pair_t upd
);
  cell_pair_t stg, stg_nxt, upd_nxt;
  logic       stg_en;

  always_comb begin
    stg_en  = capture_en | shift_en;
    stg_nxt = stg;
    if (capture_en) begin
      stg_nxt.ctl = cap_ctl;
      stg_nxt.dat = cap_dat;
    end else if (shift_en) begin
      stg_nxt.ctl = scan_in;
      stg_nxt.dat = stg.ctl;
    end
    upd_nxt = stg;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      stg <= '0;
    else if (stg_en) stg <= stg_nxt;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)         upd <= '0;
    else if (update_en) upd <= upd_nxt;
  end

  assign scan_out = stg.dat;
endmodule

// File: rtl/bscan_pin_cell.sv
module bscan_pin_cell
  import bscan_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       sys_clk,
  input  logic       sys_rst_n,
  input  logic       tck,
  input  logic       trst_n,
  input  logic [1:0] insn,
  input  logic       capture_en,
  input  logic       shift_en,
  input  logic       update_en,
  input  logic       scan_in,
  output logic       scan_out,
  input  logic       port_bit,
  input  logic       dir_bit,
  input  logic       pud,
  input  logic       clk_out_en,
  input  logic       pad_in,
  output logic       pad_oe,
  output logic       pad_out,
  output logic       pullup_en,
  output logic       pin_read,
  output logic       clk_out_pad
);
  insn_e      insn_d;
  logic       is_extest;
  logic       scan_mode;
  logic       rst_tck_n;
  logic       rst_sys_n;
  cell_pair_t upd;

  assign insn_d    = insn_e'(insn);
  assign is_extest = (insn_d == INSN_EXTEST);
  assign scan_mode = is_extest | (insn_d == INSN_SAMPLE);

  bscan_rst_sync #(.STAGES(RST_STAGES)) u_rst_tck (
    .clk(tck), .arst_n(trst_n), .rst_n(rst_tck_n)
  );

  bscan_rst_sync #(.STAGES(RST_STAGES)) u_rst_sys (
    .clk(sys_clk), .arst_n(sys_rst_n), .rst_n(rst_sys_n)
  );

  bscan_scan_reg u_scan (
    .tck(tck), .rst_n(rst_tck_n),
    .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
    .scan_in(scan_in), .cap_ctl(dir_bit), .cap_dat(pad_in),
    .scan_out(scan_out), .upd(upd)
  );

  bscan_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(sys_clk), .rst_n(rst_sys_n), .d(pad_in), .q(pin_read)
  );

  always_comb begin
    pad_oe      = is_extest ? upd.ctl : dir_bit;
    pad_out     = is_extest ? upd.dat : port_bit;
    pullup_en   = !scan_mode && !pud && !dir_bit && port_bit;
    clk_out_pad = sys_clk & clk_out_en & ~scan_mode;
  end
endmodule

// File: rtl/bscan_pin_cell_chk.sv
module bscan_pin_cell_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       sys_clk,
  input logic       tck,
  input logic       rst_tck_n,
  input logic       rst_sys_n,
  input logic [1:0] insn,
  input logic       capture_en,
  input logic       shift_en,
  input logic       update_en,
  input logic       scan_in,
  input logic       scan_out,
  input logic       port_bit,
  input logic       dir_bit,
  input logic       clk_out_en,
  input logic       pad_in,
  input logic       pad_oe,
  input logic       pad_out,
  input logic       pullup_en,
  input logic       pin_read,
  input logic       clk_out_pad
);
  logic [3:0] since_rst;
  logic       in_scan;

  assign in_scan = (insn == 2'b01) || (insn == 2'b10);

  always_ff @(posedge sys_clk or negedge rst_sys_n) begin
    if (!rst_sys_n)            since_rst <= '0;
    else if (since_rst != 4'hf) since_rst <= since_rst + 4'd1;
  end

  a_r1_normal_follow: assert property (@(posedge sys_clk)
    (insn != 2'b01) |-> (pad_oe == dir_bit && pad_out == port_bit));

  a_r3_pullup_off: assert property (@(posedge sys_clk)
    in_scan |-> !pullup_en);

  a_r4_capture_pad: assert property (@(posedge tck) disable iff (!rst_tck_n)
    (capture_en && rst_tck_n) |=> (scan_out == $past(pad_in)));

  a_r5_two_shifts: assert property (@(posedge tck) disable iff (!rst_tck_n)
    (shift_en && !capture_en && $past(shift_en && !capture_en && rst_tck_n))
    |=> (scan_out == $past(scan_in, 2)));

  a_r6_extest_hold: assert property (@(posedge tck) disable iff (!rst_tck_n)
    (insn == 2'b01 && $past(insn == 2'b01) && !$past(update_en))
    |-> ($stable(pad_oe) && $stable(pad_out)));

  a_r8_sync_delay: assert property (@(posedge sys_clk) disable iff (!rst_sys_n)
    (since_rst >= SYNC_STAGES) |-> (pin_read == $past(pad_in, SYNC_STAGES)));

  a_r9_clk_blocked: assert property (@(negedge sys_clk)
    in_scan |-> !clk_out_pad);

  a_r9_clk_passed: assert property (@(negedge sys_clk)
    (!in_scan && clk_out_en) |-> clk_out_pad);

  a_r10_scan_cleared: assert property (@(posedge tck)
    !rst_tck_n |-> !scan_out);
endmodule

bind bscan_pin_cell bscan_pin_cell_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .sys_clk(sys_clk), .tck(tck), .rst_tck_n(rst_tck_n), .rst_sys_n(rst_sys_n),
  .insn(insn), .capture_en(capture_en), .shift_en(shift_en),
  .update_en(update_en), .scan_in(scan_in), .scan_out(scan_out),
  .port_bit(port_bit), .dir_bit(dir_bit), .clk_out_en(clk_out_en),
  .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
  .pullup_en(pullup_en), .pin_read(pin_read), .clk_out_pad(clk_out_pad)
);

// File: tb/bscan_pin_cell_bench.sv
module bscan_pin_cell_bench;
  localparam int CLK_PERIOD = 10;

  logic       sys_clk = 1'b0;
  logic       sys_rst_n, tck, trst_n;
  logic [1:0] insn;
  logic       capture_en, shift_en, update_en, scan_in, scan_out;
  logic       port_bit, dir_bit, pud, clk_out_en, pad_in;
  logic       pad_oe, pad_out, pullup_en, pin_read, clk_out_pad;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

  bscan_pin_cell u_bscan_pin_cell (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .tck(tck), .trst_n(trst_n),
    .insn(insn), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .scan_in(scan_in), .scan_out(scan_out),
    .port_bit(port_bit), .dir_bit(dir_bit), .pud(pud), .clk_out_en(clk_out_en),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pullup_en(pullup_en), .pin_read(pin_read), .clk_out_pad(clk_out_pad)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tck_cycle(input logic cap, input logic sh, input logic up, input logic si);
    capture_en = cap; shift_en = sh; update_en = up; scan_in = si;
    #3 tck = 1'b1;
    #5 tck = 1'b0;
    #3;
    capture_en = 1'b0; shift_en = 1'b0; update_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge sys_clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic prev;
    sys_rst_n = 0; trst_n = 0; tck = 0; insn = 2'b00;
    capture_en = 0; shift_en = 0; update_en = 0; scan_in = 0;
    port_bit = 0; dir_bit = 0; pud = 0; clk_out_en = 0; pad_in = 0;
    #1;
    chk("R10 scan_out in reset", scan_out, 1'b0);
    chk("R10 pin_read in reset", pin_read, 1'b0);
    repeat (3) @(posedge sys_clk);
    #1 sys_rst_n = 1; trst_n = 1;
    repeat (3) tck_cycle(0, 0, 0, 0);
    repeat (3) @(posedge sys_clk);

    // R1 R2 R3 R9: exhaustive sweep of decode and register bits
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 8; v++) begin
        logic scan_m, ext;
        insn = m[1:0]; dir_bit = v[0]; port_bit = v[1]; pud = v[2];
        scan_m = (m == 1) || (m == 2);
        ext = (m == 1);
        #1;
        chk("R1 pad_oe", pad_oe, ext ? 1'b0 : v[0]);
        chk("R1 pad_out", pad_out, ext ? 1'b0 : v[1]);
        if (scan_m) chk("R3 pullup forced off", pullup_en, 1'b0);
        else chk("R2 pullup rule", pullup_en, !v[2] && !v[0] && v[1]);
      end
      for (int c = 0; c < 2; c++) begin
        clk_out_en = c[0];
        @(posedge sys_clk); #2;
        chk("R9 clock out high phase", clk_out_pad,
            c[0] && !((m == 1) || (m == 2)));
        @(negedge sys_clk); #2;
        chk("R9 clock out low phase", clk_out_pad, 1'b0);
      end
    end

    // R4: capture pad level and direction bit under sample/preload
    insn = 2'b10;
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 2; d++) begin
        pad_in = p[0]; dir_bit = d[0];
        tck_cycle(1, 0, 0, 0);
        chk("R4 captured pad level", scan_out, p[0]);
        tck_cycle(0, 1, 0, 0);
        chk("R4 captured direction", scan_out, d[0]);
      end
    end

    // R5 R7: two-stage shift, pad left alone
    for (int pat = 0; pat < 4; pat++) begin
      dir_bit = pat[0]; port_bit = pat[1];
      tck_cycle(0, 1, 0, pat[0]);
      tck_cycle(0, 1, 0, pat[1]);
      chk("R5 first bit out", scan_out, pat[0]);
      tck_cycle(0, 1, 0, 1'b0);
      chk("R5 second bit out", scan_out, pat[1]);
      chk("R7 pad_oe during shift", pad_oe, pat[0]);
      chk("R7 pad_out during shift", pad_out, pat[1]);
    end

    // R6 R7: preload, then external test drives the pad
    for (int pat = 0; pat < 4; pat++) begin
      logic c, d;
      c = pat[1]; d = pat[0];
      insn = 2'b10; dir_bit = ~c; port_bit = ~d;
      tck_cycle(0, 1, 0, d);
      tck_cycle(0, 1, 0, c);
      tck_cycle(0, 0, 1, 0);
      chk("R7 pad_oe after preload", pad_oe, ~c);
      chk("R7 pad_out after preload", pad_out, ~d);
      insn = 2'b01; #1;
      chk("R6 pad_oe from latch", pad_oe, c);
      chk("R6 pad_out from latch", pad_out, d);
      tck_cycle(0, 1, 0, ~d);
      tck_cycle(0, 1, 0, ~c);
      chk("R6 pad_oe holds without update", pad_oe, c);
      chk("R6 pad_out holds without update", pad_out, d);
      tck_cycle(0, 0, 1, 0);
      chk("R6 pad_oe after update", pad_oe, ~c);
      chk("R6 pad_out after update", pad_out, ~d);
    end

    // R8: two-flop read path
    insn = 2'b00;
    prev = pin_read;
    for (int i = 0; i < 8; i++) begin
      logic nv;
      nv = 8'b1011_0010 >> i;
      @(posedge sys_clk); #1 pad_in = nv;
      @(posedge sys_clk); #1;
      chk("R8 old value after one edge", pin_read, prev);
      @(posedge sys_clk); #1;
      chk("R8 new value after two edges", pin_read, nv);
      prev = nv;
    end

    // R10: asynchronous clear with loaded stages and latches
    pad_in = 1; insn = 2'b01;
    tck_cycle(0, 1, 0, 1);
    tck_cycle(0, 1, 0, 1);
    tck_cycle(0, 0, 1, 0);
    repeat (3) @(posedge sys_clk);
    #1;
    chk("R10 pad_oe loaded", pad_oe, 1'b1);
    chk("R10 pin_read loaded", pin_read, 1'b1);
    trst_n = 0; sys_rst_n = 0; #1;
    chk("R10 scan_out cleared", scan_out, 1'b0);
    chk("R10 pad_oe cleared", pad_oe, 1'b0);
    chk("R10 pad_out cleared", pad_out, 1'b0);
    chk("R10 pin_read cleared", pin_read, 1'b0);
    #4 trst_n = 1; sys_rst_n = 1;
    repeat (3) tck_cycle(0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule